// File: doc/BRIEF.md
# SCL High-Period Count Register with Bus-Idle Detector

This block stores the standard-speed SCL high-period count used by an I2C controller's clock generator. The count is also used to decide when the bus has gone quiet. Software writes the count through a simple write port whose data width is a parameter (8 or 16 bits). On the 8-bit variant a value is written as two byte writes. The controller's enable level gates every write. While the controller runs, the stored count is frozen and any write attempt is dropped without effect.

A 16-bit counter advances once per system clock while the synchronized SCL and SDA inputs are both high. It returns to zero as soon as either line is low. When the counter reaches the stored count plus a fixed offset of 10, the bus-idle flag rises. The counter then holds at that threshold, so the flag stays up for as long as both lines remain high. Values below a floor of 6 are raised to 6 when they are committed. Software is responsible for keeping values at or below 65525, so that the threshold still fits in 16 bits.

Top module: `scl_high_count_idle`

## Requirements
- R1: A write attempt (low byte or high byte) made while `ctrl_enable` is 1 changes neither the stored count nor the staged low byte.
- R2: A committed value below 6 is stored as 6. The floor is applied to the full 16-bit value formed after the high byte, so low byte 3 with high byte 0 stores 6, and low byte 3 with high byte 1 stores 259.
- R3: On the 8-bit bus, a write with `wr_upper`=0 only stages the low byte and leaves `high_count` unchanged. A write with `wr_upper`=1 commits {wr_data, staged low byte} in the following cycle.
- R4: The idle counter increments by one on each clock edge at which `scl_in` and `sda_in` are both 1, and clears to 0 on any edge at which either is 0.
- R5: `bus_idle` is 1 exactly when the counter has reached `high_count`+10. After the lines go high from a cleared counter, it rises after `high_count`+10 edges and stays at 1 while both lines stay high and no write occurs.
- R6: After reset, `high_count` equals the reset default of 40, the staged low byte is 0 and `bus_idle` is 0.
- R7: `high_count` always shows the stored value, including while `ctrl_enable` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the count register |
| wr_upper | input | 1 | On the 8-bit bus: 1 selects the high byte (commit), 0 selects the low byte (stage) |
| wr_data | input | DATA_W | Write data |
| ctrl_enable | input | 1 | Controller enable level; 1 blocks writes |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| high_count | output | 16 | Stored SCL high-period count |
| bus_idle | output | 1 | Bus-idle flag |

## Verification
The assertions take for granted that `scl_in` and `sda_in` are already synchronized to `clk`. They also take for granted that software never commits a value above 65525, so that the threshold and the counter cannot wrap. The stimulus only ever builds 16-bit values whose high byte stays well below 0xFF. Because the counter compares against the live count, the stimulus includes random writes, some made while the controller is disabled, that move the threshold in the middle of an idle run. The reference model checks that the flag follows the new threshold.

// File: rtl/scl_high_count_idle.sv
module scl_high_count_idle #(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 16,
  parameter int FLOOR       = 6,
  parameter int IDLE_OFFSET = 10,
  parameter int RESET_COUNT = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_upper,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ctrl_enable,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic [CNT_W-1:0]  high_count,
  output logic              bus_idle
);

  localparam logic [CNT_W-1:0] FLOOR_V = CNT_W'(FLOOR);
  localparam logic [CNT_W:0]   OFFS_V  = (CNT_W+1)'(IDLE_OFFSET);

  logic [CNT_W-1:0] hcnt_q, idle_cnt_q, wr_value, clamped;
  logic [CNT_W:0]   thr;
  logic             commit, both_high;

  generate
    if (DATA_W < CNT_W) begin : g_narrow
      logic [DATA_W-1:0] lo_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) lo_q <= '0;
        else if (wr_en && !ctrl_enable && !wr_upper) lo_q <= wr_data;
      assign wr_value = {wr_data[CNT_W-DATA_W-1:0], lo_q};
      assign commit   = wr_en && !ctrl_enable && wr_upper;

      // R3: a low-byte write only stages
      p_low_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_upper) |=> $stable(high_count));
    end else begin : g_wide
      assign wr_value = wr_data[CNT_W-1:0];
      assign commit   = wr_en && !ctrl_enable;
    end
  endgenerate

  assign clamped   = (wr_value < FLOOR_V) ? FLOOR_V : wr_value;
  assign thr       = {1'b0, hcnt_q} + OFFS_V;
  assign both_high = scl_in && sda_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hcnt_q <= CNT_W'(RESET_COUNT);
    else if (commit) hcnt_q <= clamped;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) idle_cnt_q <= '0;
    else if (!both_high) idle_cnt_q <= '0;
    else if ({1'b0, idle_cnt_q} < thr) idle_cnt_q <= idle_cnt_q + 1'b1;

  assign high_count = hcnt_q;
  assign bus_idle   = ({1'b0, idle_cnt_q} >= thr);

  p_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_enable |=> $stable(high_count));

  p_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    high_count >= FLOOR_V);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !both_high |=> (idle_cnt_q == '0) && !bus_idle);

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (both_high && !bus_idle) |=> idle_cnt_q == $past(idle_cnt_q) + 1'b1);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle && both_high && !wr_en) |=> bus_idle);

endmodule

// File: tb/test_scl_high_count_idle.sv
`timescale 1ns/1ps
module test_scl_high_count_idle;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, wr_upper = 0, ctrl_enable = 0, scl_in = 0, sda_in = 0;
  logic [7:0] wr_data = 0;
  logic [15:0] high_count;
  logic       bus_idle;

  int vectors = 0, fails = 0;
  int m_hcnt = 40, m_lo = 0, m_cnt = 0;
  string cur_req = "R6";
  bit done = 0;

  always #2.5 clk = ~clk;

  scl_high_count_idle i_scl_high_count_idle (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_upper(wr_upper), .wr_data(wr_data),
    .ctrl_enable(ctrl_enable), .scl_in(scl_in), .sda_in(sda_in),
    .high_count(high_count), .bus_idle(bus_idle));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hcnt = 40; m_lo = 0; m_cnt = 0;
    end else begin
      if (scl_in && sda_in) begin
        if (m_cnt < m_hcnt + 10) m_cnt++;
      end else m_cnt = 0;
      if (wr_en && !ctrl_enable) begin
        if (!wr_upper) m_lo = wr_data;
        else begin
          int v;
          v = wr_data * 256 + m_lo;
          m_hcnt = (v < 6) ? 6 : v;
        end
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check(cur_req, "model high_count", int'(high_count), m_hcnt);
    check(cur_req, "model bus_idle", int'(bus_idle), int'(m_cnt >= m_hcnt + 10));
  endtask

  task automatic wr(bit upper, int data);
    wr_en = 1; wr_upper = upper; wr_data = 8'(data);
    tick();
    wr_en = 0;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R6", "reset high_count", int'(high_count), 40);
    check("R6", "reset bus_idle", int'(bus_idle), 0);
    tick();

    cur_req = "R3";
    wr(0, 8'h34);
    check("R3", "after low byte", int'(high_count), 40);
    wr(1, 8'h12);
    check("R3", "after high byte", int'(high_count), 16'h1234);

    cur_req = "R2";
    wr(0, 3); wr(1, 0);
    check("R2", "floor raise", int'(high_count), 6);
    wr(0, 3); wr(1, 1);
    check("R2", "full value no floor", int'(high_count), 259);
    wr(0, 0); wr(1, 0);
    check("R2", "zero raised", int'(high_count), 6);

    cur_req = "R1";
    ctrl_enable = 1;
    wr(0, 8'h22); wr(1, 8'h01);
    check("R1", "write while enabled", int'(high_count), 6);
    check("R7", "readback while enabled", int'(high_count), 6);
    ctrl_enable = 0;
    wr(1, 0);
    check("R1", "staged low byte untouched", int'(high_count), 6);

    cur_req = "R4";
    wr(0, 20); wr(1, 0);
    check("R7", "readback disabled", int'(high_count), 20);
    scl_in = 1; sda_in = 1;
    repeat (12) tick();
    sda_in = 0; tick();
    sda_in = 1;
    repeat (29) tick();
    check("R4", "restart count no idle yet", int'(bus_idle), 0);
    cur_req = "R5";
    tick();
    check("R5", "idle at threshold", int'(bus_idle), 1);
    repeat (20) tick();
    check("R5", "idle held", int'(bus_idle), 1);
    scl_in = 0; tick();
    check("R4", "clear on scl low", int'(bus_idle), 0);
    scl_in = 1;

    cur_req = "R5";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      scl_in = (r != 0); sda_in = (r != 1);
      ctrl_enable = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 199) == 0) begin
        wr_upper = $urandom_range(0, 1);
        wr_data = wr_upper ? 8'($urandom_range(0, 1)) : 8'($urandom_range(0, 40));
        wr_en = 1;
      end else wr_en = 0;
      tick();
    end
    wr_en = 0;
    done = 1;
    report();
  end
endmodule